// File: doc/BRIEF.md
# Transfer Error Acknowledge Generator

This block closes processor data tenures that cannot finish normally. A tenure begins when `tenureStart` is seen while `dataBusy` is high and no tenure is open. The transaction classifier inputs are sampled in that cycle. From the next cycle on, the block fills one beat slot in each cycle in which `dataBusy` is high. In each slot it asserts either the normal acknowledge or the error acknowledge. Cycles in which `dataBusy` is low stall the tenure.

A transfer is flagged as an error if it falls into an unsupported class whose report bit is set, and the global error enable is on. A downstream abort reported during the tenure also flags an error. A flagged tenure is ended by a one-cycle error pulse in the next free beat slot, even partway through a burst. With the global enable off, the tenure runs to its full beat count with normal acknowledges, and the data on those beats is not meaningful. `tenureDone` marks the cycle that closes the tenure.

Top module: `teaGen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. From that edge until a new tenure is opened, `errAck`, `xferAck` and `tenureDone` stay low, even with `dataBusy` high.
- R2: Neither acknowledge is asserted in a cycle where `dataBusy` is low. Such a cycle stalls the open tenure without using up a beat slot.
- R3: `errAck` and `xferAck` are never high in the same cycle.
- R4: `errAck` lasts exactly one cycle and ends the tenure. `tenureDone` is high in that same cycle, and no acknowledge of either kind follows until a new tenure is opened.
- R5: The block decodes these unsupported classes from the inputs sampled at tenure start:
  - `xferKind`=2'b01 is a direct-store access.
  - `xferKind`=2'b10 is an external-control access, in either direction.
  - `isWrite`=1 with `addrSpace`=2'b01 or 2'b10 is a write to an interrupt-acknowledge space.
  - `isWrite`=1 with `addrSpace`=2'b11 and `flashWrEn`=0 is a boot-ROM write.
  
  When enabled, any of these gives `errAck` in the first beat slot instead of `xferAck`. Reads of those spaces, ROM writes with `flashWrEn`=1, and `xferKind` 2'b00 or 2'b11 to `addrSpace` 2'b00 are not errors.
- R6: `reportMask` gates each class. Bit 0 is direct-store, bit 1 external-control, bit 2 interrupt-acknowledge write, bit 3 boot-ROM write and bit 4 downstream abort. A class whose bit is 0 is treated as a normal transfer.
- R7: `abortFlag` high in the start cycle or in any cycle of an open tenure that does not close it causes `errAck` in the next beat slot. That pulse replaces the beat's `xferAck`. This applies when `reportMask[4]` and `errAckEn` are both 1.
- R8: With `errAckEn` low, an erroring tenure receives its full count of `xferAck` beats and never `errAck`.
- R9: A tenure with `burstXfer`=0 expects one beat, and one with `burstXfer`=1 expects `BURST_BEATS` beats. `tenureDone` is high with the last `xferAck`.
- R10: `tenureStart` is ignored while a tenure is open. Class inputs that change during the tenure have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataBusy | input | 1 | Processor data bus busy |
| tenureStart | input | 1 | Opens a data tenure (when idle and `dataBusy` high) |
| xferKind | input | 2 | Transfer kind: 00 plain, 01 direct-store, 10 external-control, 11 plain |
| isWrite | input | 1 | Transfer direction, 1 = write |
| addrSpace | input | 2 | Address class: 00 memory, 01/10 interrupt-acknowledge spaces, 11 boot ROM |
| flashWrEn | input | 1 | Boot-ROM writes permitted |
| abortFlag | input | 1 | Downstream transfer aborted |
| burstXfer | input | 1 | 1 = burst tenure, 0 = single beat |
| reportMask | input | 5 | Per-class report enables (bit map in R6) |
| errAckEn | input | 1 | Global error-acknowledge enable |
| errAck | output | 1 | Transfer error acknowledge pulse |
| xferAck | output | 1 | Normal transfer acknowledge |
| tenureDone | output | 1 | High in the cycle that closes the tenure |

## Verification
The bench builds the block with the default `BURST_BEATS` of 4. With four beats, an abort can land before the first, second, middle or last beat slot, and can also arrive in the closing cycle, where it must be ignored. Random stalls on `dataBusy` shift those slots in time, so the placement of the error pulse is tested against stalls as well as beat position. Class inputs and `tenureStart` are toggled while a tenure is open to confirm that they are ignored.

// File: rtl/teaPkg.sv
package teaPkg;
  localparam int NUM_ERR_CLASSES = 5;
  localparam int IDX_DIRECT = 0;
  localparam int IDX_EXTCTL = 1;
  localparam int IDX_INTACK = 2;
  localparam int IDX_ROMWR  = 3;
  localparam int IDX_ABORT  = 4;

  localparam logic [1:0] KIND_DIRECT = 2'b01;
  localparam logic [1:0] KIND_EXTCTL = 2'b10;
  localparam logic [1:0] SPACE_IACK_A = 2'b01;
  localparam logic [1:0] SPACE_IACK_B = 2'b10;
  localparam logic [1:0] SPACE_ROM    = 2'b11;

  typedef enum logic {ST_IDLE, ST_BUSY} ctlStateT;

  typedef struct packed {
    logic loadTenure;
    logic issueBeat;
    logic endTenure;
    logic watchAbort;
  } ctlStrobeT;
endpackage

// File: rtl/teaDatapath.sv
module teaDatapath
  import teaPkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStrobeT                  strobe,
  input  logic [1:0]                 xferKind,
  input  logic                       isWrite,
  input  logic [1:0]                 addrSpace,
  input  logic                       flashWrEn,
  input  logic                       abortFlag,
  input  logic                       burstXfer,
  input  logic [NUM_ERR_CLASSES-1:0] reportMask,
  input  logic                       errAckEn,
  output logic                       errPending,
  output logic                       lastBeat
);
  localparam int CNT_W = $clog2(BURST_BEATS + 1);

  logic [NUM_ERR_CLASSES-1:0] classVec;
  logic [CNT_W-1:0] beatsLeft;
  logic startErr;
  logic abortHit;

  always_comb begin
    classVec = '0;
    classVec[IDX_DIRECT] = (xferKind == KIND_DIRECT);
    classVec[IDX_EXTCTL] = (xferKind == KIND_EXTCTL);
    classVec[IDX_INTACK] = isWrite && ((addrSpace == SPACE_IACK_A) || (addrSpace == SPACE_IACK_B));
    classVec[IDX_ROMWR]  = isWrite && (addrSpace == SPACE_ROM) && !flashWrEn;
    classVec[IDX_ABORT]  = 1'b0;
  end

  assign startErr = errAckEn && (|(classVec & reportMask));
  assign abortHit = errAckEn && abortFlag && reportMask[IDX_ABORT];
  assign lastBeat = (beatsLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      beatsLeft  <= '0;
      errPending <= 1'b0;
    end else if (strobe.loadTenure) begin
      beatsLeft  <= burstXfer ? CNT_W'(BURST_BEATS) : CNT_W'(1);
      errPending <= startErr || abortHit;
    end else begin
      if (strobe.issueBeat && (beatsLeft != '0))
        beatsLeft <= beatsLeft - CNT_W'(1);
      if (strobe.endTenure)
        errPending <= 1'b0;
      else if (strobe.watchAbort && abortHit)
        errPending <= 1'b1;
    end
  end

  AST_BEAT_AVAILABLE: assert property (@(posedge clk) disable iff (rst)
    strobe.issueBeat |-> (beatsLeft != '0)); // R9
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (rst)
    strobe.loadTenure |=> ((beatsLeft == CNT_W'(1)) || (beatsLeft == CNT_W'(BURST_BEATS)))); // R9
  AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadTenure && !errAckEn) |=> !errPending); // R8
endmodule

// File: rtl/teaControl.sv
module teaControl
  import teaPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dataBusy,
  input  logic      tenureStart,
  input  logic      errPending,
  input  logic      lastBeat,
  output ctlStrobeT strobe,
  output logic      errAck,
  output logic      xferAck,
  output logic      tenureDone
);
  ctlStateT state;
  logic inBusy;
  logic errFire;
  logic beatFire;

  assign inBusy   = (state == ST_BUSY);
  assign errFire  = inBusy && dataBusy && errPending;
  assign beatFire = inBusy && dataBusy && !errPending;

  always_comb begin
    strobe.loadTenure = (state == ST_IDLE) && tenureStart && dataBusy;
    strobe.issueBeat  = beatFire;
    strobe.endTenure  = errFire || (beatFire && lastBeat);
    strobe.watchAbort = inBusy;
  end

  assign errAck     = errFire;
  assign xferAck    = beatFire;
  assign tenureDone = strobe.endTenure;

  always_ff @(posedge clk) begin
    if (rst)
      state <= ST_IDLE;
    else if (strobe.loadTenure)
      state <= ST_BUSY;
    else if (strobe.endTenure)
      state <= ST_IDLE;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!errAck && !xferAck)); // R1
  AST_ACK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (errAck || xferAck) |-> dataBusy); // R2
  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({errAck, xferAck}) <= 1); // R3
  AST_ERR_TERMINATES: assert property (@(posedge clk) disable iff (rst)
    errAck |=> (!errAck && !xferAck)); // R4
  AST_ERR_MARKS_DONE: assert property (@(posedge clk) disable iff (rst)
    errAck |-> tenureDone); // R4
endmodule

// File: rtl/teaGen.sv
module teaGen
  import teaPkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dataBusy,
  input  logic       tenureStart,
  input  logic [1:0] xferKind,
  input  logic       isWrite,
  input  logic [1:0] addrSpace,
  input  logic       flashWrEn,
  input  logic       abortFlag,
  input  logic       burstXfer,
  input  logic [4:0] reportMask,
  input  logic       errAckEn,
  output logic       errAck,
  output logic       xferAck,
  output logic       tenureDone
);
  ctlStrobeT strobe;
  logic errPending;
  logic lastBeat;

  teaControl uCtl (
    .clk        (clk),
    .rst        (rst),
    .dataBusy   (dataBusy),
    .tenureStart(tenureStart),
    .errPending (errPending),
    .lastBeat   (lastBeat),
    .strobe     (strobe),
    .errAck     (errAck),
    .xferAck    (xferAck),
    .tenureDone (tenureDone)
  );

  teaDatapath #(.BURST_BEATS(BURST_BEATS)) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .xferKind  (xferKind),
    .isWrite   (isWrite),
    .addrSpace (addrSpace),
    .flashWrEn (flashWrEn),
    .abortFlag (abortFlag),
    .burstXfer (burstXfer),
    .reportMask(reportMask),
    .errAckEn  (errAckEn),
    .errPending(errPending),
    .lastBeat  (lastBeat)
  );
endmodule

// File: tb/tb_teaGen.sv
module tb_teaGen;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataBusy = 1'b0;
  logic tenureStart = 1'b0;
  logic [1:0] xferKind = 2'b00;
  logic isWrite = 1'b0;
  logic [1:0] addrSpace = 2'b00;
  logic flashWrEn = 1'b0;
  logic abortFlag = 1'b0;
  logic burstXfer = 1'b0;
  logic [4:0] reportMask = 5'h1f;
  logic errAckEn = 1'b1;
  logic errAck, xferAck, tenureDone;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  teaGen #(.BURST_BEATS(BEATS)) dut (
    .clk(clk), .rst(rst), .dataBusy(dataBusy), .tenureStart(tenureStart),
    .xferKind(xferKind), .isWrite(isWrite), .addrSpace(addrSpace),
    .flashWrEn(flashWrEn), .abortFlag(abortFlag), .burstXfer(burstXfer),
    .reportMask(reportMask), .errAckEn(errAckEn),
    .errAck(errAck), .xferAck(xferAck), .tenureDone(tenureDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic checkOuts(input string tag, input logic eErr, input logic eAck, input logic eDone);
    check(tag, "errAck", errAck, eErr);
    check(tag, "xferAck", xferAck, eAck);
    check(tag, "tenureDone", tenureDone, eDone);
    check("R3", "ack exclusivity", errAck & xferAck, 1'b0);
  endtask

  function automatic bit expStartErr(input logic [1:0] kind, input logic wr, input logic [1:0] space,
                                     input logic flash, input logic [4:0] mask, input logic en);
    bit hit;
    hit = (kind == 2'b01 && mask[0]) || (kind == 2'b10 && mask[1]) ||
          (wr && (space == 2'b01 || space == 2'b10) && mask[2]) ||
          (wr && space == 2'b11 && !flash && mask[3]);
    return en && hit;
  endfunction

  task automatic runTenure(input string tag, input logic [1:0] kind, input logic wr,
                           input logic [1:0] space, input logic flash, input logic burst,
                           input logic [4:0] mask, input logic en, input int abortAt,
                           input int stallPct, input bit noise);
    int expBeats;
    int got;
    bit pend;
    bit done;
    int cyc;
    logic busy, eErr, eAck, eDone;
    @(negedge clk);
    dataBusy = 1'b1; tenureStart = 1'b1;
    xferKind = kind; isWrite = wr; addrSpace = space; flashWrEn = flash;
    burstXfer = burst; reportMask = mask; errAckEn = en;
    abortFlag = (abortAt == 0);
    #2 checkOuts(tag, 1'b0, 1'b0, 1'b0);
    expBeats = burst ? BEATS : 1;
    pend = expStartErr(kind, wr, space, flash, mask, en) || ((abortAt == 0) && en && mask[4]);
    got = 0; done = 0; cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      busy = (int'($urandom % 100) >= stallPct);
      dataBusy = busy;
      abortFlag = (cyc == abortAt);
      tenureStart = noise ? 1'($urandom % 2) : 1'b0;
      if (noise) begin
        xferKind = 2'($urandom); isWrite = 1'($urandom); addrSpace = 2'($urandom);
        flashWrEn = 1'($urandom); burstXfer = 1'($urandom);
      end
      eErr = busy && pend;
      eAck = busy && !pend;
      eDone = eErr || (eAck && (got + 1 == expBeats));
      #2 checkOuts(tag, eErr, eAck, eDone);
      if (eAck) got++;
      if (eDone) done = 1;
      else if (abortFlag && en && mask[4]) pend = 1;
      cyc++;
    end
    @(negedge clk);
    tenureStart = 1'b0; abortFlag = 1'b0; dataBusy = 1'b1;
    #2 checkOuts("R4", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    dataBusy = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (2) @(negedge clk);
    dataBusy = 1'b1;
    #2 checkOuts("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    dataBusy = 1'b0;

    // R9: plain single and burst
    runTenure("R9", 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R9", 2'b00, 1'b1, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R9", 2'b11, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    // R5: each unsupported class, and non-error neighbours
    runTenure("R5", 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b10, 1'b1, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b00, 1'b1, 2'b11, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b00, 1'b0, 2'b01, 1'b0, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    runTenure("R5", 2'b00, 1'b1, 2'b11, 1'b1, 1'b1, 5'h1f, 1'b1, -1, 0, 0);
    // R6: mask bit cleared for each class
    runTenure("R6", 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1e, 1'b1, -1, 0, 0);
    runTenure("R6", 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1d, 1'b1, -1, 0, 0);
    runTenure("R6", 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, 5'h1b, 1'b1, -1, 0, 0);
    runTenure("R6", 2'b00, 1'b1, 2'b11, 1'b0, 1'b1, 5'h17, 1'b1, -1, 0, 0);
    runTenure("R6", 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 5'h0f, 1'b1, 2, 0, 0);
    // R7: abort at start, before each slot, and on the closing beat
    for (int a = 0; a <= BEATS; a++)
      runTenure("R7", 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b1, a, 0, 0);
    runTenure("R7", 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 5'h1f, 1'b1, 0, 0, 0);
    // R8: global enable off
    runTenure("R8", 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 5'h1f, 1'b0, -1, 0, 0);
    runTenure("R8", 2'b00, 1'b1, 2'b11, 1'b0, 1'b1, 5'h1f, 1'b0, 2, 0, 0);
    // R2: heavy stalling
    for (int i = 0; i < 10; i++)
      runTenure("R2", 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'b1,
                5'($urandom), 1'b1, int'($urandom % 6) - 1, 60, 0);
    // R10: restart and class noise during open tenures
    for (int i = 0; i < 20; i++)
      runTenure("R10", 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                5'($urandom), 1'($urandom), int'($urandom % 6) - 1, 25, 1);

    // R1: reset in the middle of a burst
    @(negedge clk);
    dataBusy = 1'b1; tenureStart = 1'b1; xferKind = 2'b00; isWrite = 1'b0;
    addrSpace = 2'b00; burstXfer = 1'b1; errAckEn = 1'b1; reportMask = 5'h1f; abortFlag = 1'b0;
    @(negedge clk);
    tenureStart = 1'b0;
    #2 checkOuts("R1", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2 checkOuts("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #2 checkOuts("R1", 1'b0, 1'b0, 1'b0);
    dataBusy = 1'b0;

    // Mixed random tenures
    for (int i = 0; i < 300; i++)
      runTenure("R9", 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                5'($urandom), 1'($urandom), int'($urandom % 7) - 1, 20, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule